// File: doc/BRIEF.md
# Three-Format Instruction Field Decoder

This block inspects a 32-bit instruction word and decides whether it is one of three integer formats: a register-register add, an add with a 12-bit immediate, or a word store. It raises one bit of a match vector for the format it finds. It also pulls out the register indices and the immediate that belong to that format. A word that fits none of the three raises an illegal flag instead. The store format splits its immediate across two places in the word. The decoder joins the two parts back into one contiguous 12-bit value, so a consumer sees the same immediate layout for both immediate formats.

Any field that the recognised format does not carry is driven to zero. The immediate leaves the block as 12 raw bits, and any widening is done by the consumer. A parameter selects one of two output stages. One is a register stage with a valid input and a valid output and a synchronous active-low reset. The other is a pass-through with no latency.

Top module: `rvsub_decoder`

## Requirements
- R1: The add format is recognised when bits[6:0]=0110011, bits[14:12]=000 and bits[31:25]=0000000. The block then outputs rd=bits[11:7], rs1=bits[19:15] and rs2=bits[24:20].
- R2: The add-immediate format is recognised when bits[6:0]=0010011 and bits[14:12]=000, whatever bits[31:20] hold. The block then outputs rd=bits[11:7], rs1=bits[19:15] and imm=bits[31:20].
- R3: The store-word format is recognised when bits[6:0]=0100011 and bits[14:12]=010. The block then outputs rs1=bits[19:15] and rs2=bits[24:20], with imm[11:5]=bits[31:25] and imm[4:0]=bits[11:7]. For example, 0x801120A3 gives rs2=1, rs1=2 and imm=0x801.
- R4: The match vector has bit 0 for add, bit 1 for add-immediate and bit 2 for store-word, and at most one of its bits is high.
- R5: A word that matches no format sets the illegal flag, leaves the match vector at zero and drives rd, rs1, rs2 and imm to zero.
- R6: Fields that the matched format does not use are zero: imm for add, rs2 for add-immediate, and rd for store-word.
- R7: An add whose bits[31:25] are not all zero is illegal, and so is any word with one of its opcode or funct3 bits corrupted, unless the corrupted word happens to match another format. For add-immediate, bits[31:25] are part of the immediate and never affect the decode.
- R8: With the register stage on (REG_OUT=1, the default), the outputs show the decode of the word presented one clock earlier. out_valid equals in_valid of the previous cycle. A cycle with in_valid low leaves the match vector, the illegal flag and all the fields unchanged.
- R9: While rst_n is low at a clock edge, the register stage clears out_valid, the match vector, the illegal flag and all the fields to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | The instruction word on in_instr is valid |
| in_instr | input | 32 | Instruction word to decode |
| out_valid | output | 1 | The decode outputs are valid |
| out_match | output | 3 | One-hot format: bit 0 add, bit 1 add-immediate, bit 2 store-word |
| out_illegal | output | 1 | The word matched no format |
| out_rd | output | 5 | Destination register index |
| out_rs1 | output | 5 | First source register index |
| out_rs2 | output | 5 | Second source register index |
| out_imm | output | 12 | Immediate, contiguous, not sign-extended |

## Verification
The bench goes after the split store immediate, including the example word with imm=0x801. A decoder that swapped or shifted the two parts would report a wrong immediate there, and it would also fail on random stores. Add words with a non-zero upper field must come out illegal, and add-immediate words with that same field full of ones must still decode. Checking both catches a decoder that applies the add mask to the wrong format. The bench flips single opcode and funct3 bits and compares the result against a behavioural model, which finds a loose mask that lets a corrupt word through. Idle cycles between words expose a register stage that fails to hold its outputs.

// File: rtl/rvsub_pkg.sv
// Package: shared constants, the field bundle and the per-format bit patterns.
// Assumes 32-bit instruction words and exactly three recognised formats.
package rvsub_pkg;
    localparam int ILEN    = 32;
    localparam int REGW    = 5;
    localparam int IMMW    = 12;
    localparam int NFMT    = 3;
    localparam int OPW     = 7;
    localparam int PAYW    = ILEN - OPW;

    // Match vector positions
    localparam int FMT_ADD  = 0;
    localparam int FMT_ADDI = 1;
    localparam int FMT_SW   = 2;

    typedef struct packed {
        logic [REGW-1:0] rd;
        logic [REGW-1:0] rs1;
        logic [REGW-1:0] rs2;
        logic [IMMW-1:0] imm;
    } fields_t;

    // Bits that must hold a fixed value for format idx
    function automatic logic [ILEN-1:0] fmt_mask(input int idx);
        case (idx)
            FMT_ADD: fmt_mask = 32'hFE00_707F;
            default: fmt_mask = 32'h0000_707F;
        endcase
    endfunction

    // The fixed value under fmt_mask for format idx
    function automatic logic [ILEN-1:0] fmt_value(input int idx);
        case (idx)
            FMT_ADD:  fmt_value = 32'h0000_0033;
            FMT_ADDI: fmt_value = 32'h0000_0013;
            default:  fmt_value = 32'h0000_2023;
        endcase
    endfunction
endpackage

// File: rtl/rvsub_matcher.sv
// Matcher: compares the word against each format's fixed-bit pattern, one
// comparator per format. Assumes the patterns in the package are mutually
// exclusive, which makes the hit vector one-hot or zero.
module rvsub_matcher
    import rvsub_pkg::*;
(
    input  logic [ILEN-1:0] instr,
    output logic [NFMT-1:0] hit,
    output logic            illegal
);
    genvar g;
    generate
        for (g = 0; g < NFMT; g++) begin : g_fmt
            // Masked compare of one format's fixed bits
            assign hit[g] = ((instr & fmt_mask(g)) == fmt_value(g));
        end
    endgenerate

    // No format matched
    assign illegal = ~|hit;

    // Checks that the patterns are exclusive
    always_comb begin
        assert_hit_onehot_R4: assert ($onehot0(hit) || $isunknown(instr));
    end
endmodule

// File: rtl/rvsub_fields.sv
// Field extractor: picks rd/rs1/rs2/imm from the word above the opcode for
// the single matched format, rebuilding the split store immediate.
// Assumes hit is one-hot or zero; unused fields are forced to zero.
module rvsub_fields
    import rvsub_pkg::*;
(
    input  logic [PAYW-1:0] payload,   // instruction bits [31:7]
    input  logic [NFMT-1:0] hit,
    output fields_t         f
);
    // Word bit b sits at payload index b-OPW
    localparam int RD_LO  = 7  - OPW;
    localparam int RS1_LO = 15 - OPW;
    localparam int RS2_LO = 20 - OPW;
    localparam int IHI_LO = 25 - OPW;   // upper store imm part / add funct7
    localparam int IMM_LO = 20 - OPW;   // add-immediate imm

    logic [REGW-1:0] w_rd, w_rs1, w_rs2;
    logic [IMMW-1:0] w_imm_i, w_imm_s;

    // Raw slices common to several formats
    always_comb begin
        w_rd    = payload[RD_LO  +: REGW];
        w_rs1   = payload[RS1_LO +: REGW];
        w_rs2   = payload[RS2_LO +: REGW];
        w_imm_i = payload[IMM_LO +: IMMW];
        w_imm_s = {payload[IHI_LO +: (IMMW-REGW)], payload[RD_LO +: REGW]};
    end

    // Route the slices of the matched format, zero otherwise
    always_comb begin
        f = '0;
        if (hit[FMT_ADD]) begin
            f.rd  = w_rd;
            f.rs1 = w_rs1;
            f.rs2 = w_rs2;
        end else if (hit[FMT_ADDI]) begin
            f.rd  = w_rd;
            f.rs1 = w_rs1;
            f.imm = w_imm_i;
        end else if (hit[FMT_SW]) begin
            f.rs1 = w_rs1;
            f.rs2 = w_rs2;
            f.imm = w_imm_s;
        end
    end
endmodule

// File: rtl/rvsub_outstage.sv
// Output stage: REG_OUT=1 registers the decode behind in_valid (hold when
// idle, synchronous active-low reset); REG_OUT=0 passes it straight through.
module rvsub_outstage
    import rvsub_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [NFMT-1:0] hit,
    input  logic            illegal,
    input  fields_t         f,
    output logic            out_valid,
    output logic [NFMT-1:0] out_hit,
    output logic            out_illegal,
    output fields_t         out_f
);
    generate
        if (REG_OUT) begin : g_reg
            logic            q_valid;
            logic [NFMT-1:0] q_hit;
            logic            q_ill;
            fields_t         q_f;
            logic            armed;

            // Capture the decode when a word is presented
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q_valid <= 1'b0;
                    q_hit   <= '0;
                    q_ill   <= 1'b0;
                    q_f     <= '0;
                end else begin
                    q_valid <= in_valid;
                    if (in_valid) begin
                        q_hit <= hit;
                        q_ill <= illegal;
                        q_f   <= f;
                    end
                end
            end

            // Marks that one full cycle out of reset has passed
            always_ff @(posedge clk) begin
                if (!rst_n) armed <= 1'b0;
                else        armed <= 1'b1;
            end

            assign out_valid   = q_valid;
            assign out_hit     = q_hit;
            assign out_illegal = q_ill;
            assign out_f       = q_f;

            assert_valid_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
                armed |-> (out_valid == $past(in_valid)));
            assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (armed && !$past(in_valid)) |-> ($stable(out_f) && $stable(out_hit) && $stable(out_illegal)));
        end else begin : g_comb
            assign out_valid   = in_valid;
            assign out_hit     = hit;
            assign out_illegal = illegal;
            assign out_f       = f;
        end
    endgenerate
endmodule

// File: rtl/rvsub_decoder.sv
// Top: three-format instruction decoder. Matcher and field extractor are
// combinational; rvsub_outstage adds an optional register stage.
// Assumes in_instr is stable while in_valid is sampled.
module rvsub_decoder
    import rvsub_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] in_instr,
    output logic        out_valid,
    output logic [2:0]  out_match,
    output logic        out_illegal,
    output logic [4:0]  out_rd,
    output logic [4:0]  out_rs1,
    output logic [4:0]  out_rs2,
    output logic [11:0] out_imm
);
    logic [NFMT-1:0] hit;
    logic            illegal;
    fields_t         fld;
    fields_t         o_f;

    rvsub_matcher u_match (
        .instr   (in_instr),
        .hit     (hit),
        .illegal (illegal)
    );

    rvsub_fields u_fields (
        .payload (in_instr[ILEN-1:OPW]),
        .hit     (hit),
        .f       (fld)
    );

    rvsub_outstage #(.REG_OUT(REG_OUT)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .hit         (hit),
        .illegal     (illegal),
        .f           (fld),
        .out_valid   (out_valid),
        .out_hit     (out_match),
        .out_illegal (out_illegal),
        .out_f       (o_f)
    );

    // Unpack the field bundle onto the ports
    always_comb begin
        out_rd  = o_f.rd;
        out_rs1 = o_f.rs1;
        out_rs2 = o_f.rs2;
        out_imm = o_f.imm;
    end

    assert_match_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_match));
    assert_illegal_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (out_match == '0 && out_rd == '0 && out_rs1 == '0 && out_rs2 == '0 && out_imm == '0));
    assert_add_no_imm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_match[FMT_ADD] |-> (out_imm == '0));
    assert_addi_no_rs2_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_match[FMT_ADDI] |-> (out_rs2 == '0));
    assert_sw_no_rd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_match[FMT_SW] |-> (out_rd == '0));
endmodule

// File: tb/rvsub_decoder_tb_top.sv
`timescale 1ns/1ps
module rvsub_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] in_instr;
    logic        out_valid;
    logic [2:0]  out_match;
    logic        out_illegal;
    logic [4:0]  out_rd, out_rs1, out_rs2;
    logic [11:0] out_imm;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    rvsub_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
        .out_valid(out_valid), .out_match(out_match), .out_illegal(out_illegal),
        .out_rd(out_rd), .out_rs1(out_rs1), .out_rs2(out_rs2), .out_imm(out_imm)
    );

    typedef struct packed {
        logic [2:0]  m;
        logic        ill;
        logic [4:0]  rd, rs1, rs2;
        logic [11:0] imm;
    } exp_t;

    exp_t held = '0;

    // Behavioural reference decode
    function automatic exp_t ref_dec(input logic [31:0] w);
        exp_t e = '0;
        if (w[6:0] == 7'b0110011 && w[14:12] == 3'b000 && w[31:25] == 7'd0) begin
            e.m = 3'b001; e.rd = w[11:7]; e.rs1 = w[19:15]; e.rs2 = w[24:20];
        end else if (w[6:0] == 7'b0010011 && w[14:12] == 3'b000) begin
            e.m = 3'b010; e.rd = w[11:7]; e.rs1 = w[19:15]; e.imm = w[31:20];
        end else if (w[6:0] == 7'b0100011 && w[14:12] == 3'b010) begin
            e.m = 3'b100; e.rs1 = w[19:15]; e.rs2 = w[24:20]; e.imm = {w[31:25], w[11:7]};
        end else begin
            e.ill = 1'b1;
        end
        return e;
    endfunction

    function automatic string tag_of(input exp_t e);
        if (e.m[0]) return "R1/R6";
        if (e.m[1]) return "R2/R6";
        if (e.m[2]) return "R3/R6";
        return "R5";
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic cmp_all(input string tag, input logic exp_v);
        chk("R8", "out_valid", 32'(out_valid), 32'(exp_v));
        chk("R4", "onehot", 32'($countones(out_match) <= 1), 32'd1);
        chk(tag, "match", 32'(out_match), 32'(held.m));
        chk(tag, "illegal", 32'(out_illegal), 32'(held.ill));
        chk(tag, "rd", 32'(out_rd), 32'(held.rd));
        chk(tag, "rs1", 32'(out_rs1), 32'(held.rs1));
        chk(tag, "rs2", 32'(out_rs2), 32'(held.rs2));
        chk(tag, "imm", 32'(out_imm), 32'(held.imm));
    endtask

    // Drive one word at a falling edge, check the registered result one cycle on
    task automatic step(input logic v, input logic [31:0] w, input string tag_ovr);
        string t;
        in_valid = v;
        in_instr = w;
        @(negedge clk);
        if (v) held = ref_dec(w);
        t = (tag_ovr != "") ? tag_ovr : (v ? tag_of(held) : "R8");
        cmp_all(t, v);
    endtask

    function automatic logic [31:0] mk_add(input logic [4:0] rd, rs1, rs2);
        return {7'd0, rs2, rs1, 3'b000, rd, 7'b0110011};
    endfunction
    function automatic logic [31:0] mk_addi(input logic [11:0] imm, input logic [4:0] rd, rs1);
        return {imm, rs1, 3'b000, rd, 7'b0010011};
    endfunction
    function automatic logic [31:0] mk_sw(input logic [11:0] imm, input logic [4:0] rs1, rs2);
        return {imm[11:5], rs2, rs1, 3'b010, imm[4:0], 7'b0100011};
    endfunction

    function automatic logic [31:0] rnd_legal(input int k);
        case (k % 3)
            0:       return mk_add(5'($urandom), 5'($urandom), 5'($urandom));
            1:       return mk_addi(12'($urandom), 5'($urandom), 5'($urandom));
            default: return mk_sw(12'($urandom), 5'($urandom), 5'($urandom));
        endcase
    endfunction

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_instr = '0;
        repeat (3) @(negedge clk);
        // R9: cleared state under reset
        cmp_all("R9", 1'b0);
        rst_n = 1'b1;

        // R3: worked example 0x801120A3
        step(1'b1, 32'h8011_20A3, "R3");
        chk("R3", "example imm", 32'(out_imm), 32'h801);
        chk("R3", "example rs2", 32'(out_rs2), 32'd1);
        chk("R3", "example rs1", 32'(out_rs1), 32'd2);

        // R1 directed
        step(1'b1, mk_add(5'd31, 5'd17, 5'd9), "R1");
        chk("R1", "add match", 32'(out_match), 32'b001);
        // R7: add with non-zero upper field is illegal
        step(1'b1, mk_add(5'd3, 5'd4, 5'd5) | 32'h4000_0000, "R7");
        chk("R7", "sub-like illegal", 32'(out_illegal), 32'd1);
        // R2/R7: add-immediate with all-ones immediate still decodes
        step(1'b1, mk_addi(12'hFFF, 5'd1, 5'd2), "R7");
        chk("R2", "addi imm", 32'(out_imm), 32'hFFF);
        chk("R7", "addi match", 32'(out_match), 32'b010);
        // R5: all-zero word
        step(1'b1, 32'h0000_0000, "R5");
        chk("R5", "zero word illegal", 32'(out_illegal), 32'd1);

        // R8: idle cycles hold the last decode
        step(1'b1, mk_sw(12'hA5C, 5'd7, 5'd8), "R3");
        for (int i = 0; i < 3; i++) step(1'b0, 32'($urandom), "R8");
        chk("R8", "hold imm", 32'(out_imm), 32'hA5C);

        // Random legal words of all three formats
        for (int i = 0; i < 300; i++) begin
            step(1'b1, rnd_legal(i), "");
            if ($urandom_range(0, 7) == 0) step(1'b0, 32'($urandom), "R8");
        end

        // R7: single-bit corruption of opcode, funct3 or (for add) funct7
        for (int i = 0; i < 240; i++) begin
            logic [31:0] w;
            int b;
            w = rnd_legal(i);
            case ($urandom_range(0, 2))
                0:       b = $urandom_range(0, 6);
                1:       b = $urandom_range(12, 14);
                default: b = (i % 3 == 0) ? $urandom_range(25, 31) : $urandom_range(0, 6);
            endcase
            w[b] = ~w[b];
            step(1'b1, w, "R7");
        end

        // R9: reset in mid-run clears the stage
        in_valid = 1'b1; in_instr = mk_add(5'd1, 5'd1, 5'd1);
        rst_n = 1'b0;
        @(negedge clk);
        held = '0;
        cmp_all("R9", 1'b0);
        rst_n = 1'b1;
        step(1'b1, mk_addi(12'h123, 5'd4, 5'd5), "R2");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        #(5ns * 20000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule